// File: doc/BRIEF.md
# SD Command Word Collector

This block sits behind one write-only host register address and builds a 48-bit SD card command out of several consecutive host writes. When the bus is configured 16 bits wide, the host writes three words. When it is configured 8 bits wide, the host writes six bytes. Each write fills the next slot, starting from the most significant end of the command. After the final piece lands, the block presents the complete command on a 48-bit output and raises a single-cycle start strobe. A serial transmitter downstream picks up both.

An auto-CRC input lets the block compute the 7-bit command checksum itself. When it is set, whatever the host wrote into the checksum field is replaced by the computed value. The end bit is always forced to 1. In byte mode with auto-CRC, the host must still write the sixth byte, but only its arrival matters, not its value. A hardware reset or a synchronous software reset clears the slot pointer and the command contents.

Top module: `sd_cmd_pipe`

## Requirements
- R1: With `byte_mode`=0, three writes are collected. The first lands in command bits 47:32, the second in 31:16 and the third in 15:0, before the checksum and end-bit rules are applied.
- R2: Bit 0 of every command presented with a start strobe is 1, whatever value was written there.
- R3: With `crc_auto`=1, bits 7:1 of the presented command hold the CRC7 of bits 47:8. The CRC uses polynomial x^7+x^3+1, starts from zero and runs MSB first. The written bits 7:1 are ignored. A command 0x40 followed by a zero argument therefore ends in byte 0x95.
- R4: With `crc_auto`=0, bits 7:1 of the presented command are the written values.
- R5: `cmd_start` is high for exactly one cycle. That cycle follows the clock edge that samples the last write of a sequence, and the strobe never rises earlier. `cmd_word` takes the new command in that same cycle and holds it until the next strobe or reset.
- R6: With `byte_mode`=1, six writes are collected from `wr_data[7:0]`, most significant byte first, landing in bits 47:40 down to 7:0. `wr_data[15:8]` is ignored.
- R7: In byte mode with `crc_auto`=1, the sixth byte is still required to trigger the strobe, but its content has no effect on the presented command.
- R8: After a strobe, the slot pointer is back at the first slot, so commands can follow one another directly.
- R9: While `rst_n` is low, `cmd_word` is 0, `cmd_start` is 0 and the slot pointer is cleared, including in the middle of a sequence.
- R10: A cycle with `soft_rst`=1 clears `cmd_word`, `cmd_start` and the slot pointer. It takes priority over a write in the same cycle.
- R11: Cycles with `wr_en`=0 change neither the slot pointer nor `cmd_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Host write strobe to the command address, one cycle per piece |
| wr_data | input | 16 | Host write data; only bits 7:0 used in byte mode |
| byte_mode | input | 1 | 1 = six 8-bit writes, 0 = three 16-bit writes |
| crc_auto | input | 1 | 1 = substitute the computed CRC7 into bits 7:1 |
| cmd_word | output | 48 | Last completed command |
| cmd_start | output | 1 | One-cycle pulse when a new command is ready |

## Verification
The bench fills the low command bits with junk whenever auto-CRC is on. A design that let written checksum bits leak through, or that computed the CRC over the wrong span, would then present a wrong low byte, and the all-zero-argument CMD0 vector pins down the 0x95 result. Upper data bits are driven with junk in byte mode, which exposes any design that merges them. A soft reset is applied in the middle of a sequence, in the same cycle as a write, and is followed by a complete command. A pointer that was not cleared, or that let the write win, would misplace every later piece. The bench also watches for the strobe after each piece but the last. A pointer with an off-by-one end count would fire early or one write late.

// File: rtl/sdcp_pkg.sv
package sdcp_pkg;
  localparam int SDCP_CMD_W   = 48;
  localparam int SDCP_CRC_LO  = 8;
  localparam int SDCP_CRC_SPAN = SDCP_CMD_W - SDCP_CRC_LO;

  // CRC7, polynomial x^7 + x^3 + 1, zero seed, MSB first.
  function automatic logic [6:0] sdcp_crc7(input logic [SDCP_CRC_SPAN-1:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = SDCP_CRC_SPAN - 1; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sdcp_ptr.sv
module sdcp_ptr #(
  parameter int N_WIDE   = 3,
  parameter int N_NARROW = 6,
  parameter int PW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          narrow,
  output logic [PW-1:0] ptr,
  output logic          last_hit
);
  logic [PW-1:0] end_slot;

  assign end_slot = narrow ? PW'(N_NARROW - 1) : PW'(N_WIDE - 1);
  assign last_hit = adv && !clr && (ptr == end_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (clr)      ptr <= '0;
    else if (last_hit) ptr <= '0;
    else if (adv)      ptr <= ptr + 1'b1;
  end

  // R8: pointer wraps to the first slot after the final piece
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(last_hit) |-> (ptr == '0));
  // R10: software reset leaves the pointer at zero
  p_clr_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (ptr == '0));
  // R11: idle cycles keep the pointer
  p_idle_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(adv) && !$past(clr)) |-> $stable(ptr));
  // R6: pointer stays inside the byte-mode slot range
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(N_NARROW));
endmodule

// File: rtl/sdcp_gather.sv
module sdcp_gather #(
  parameter int CMD_W    = 48,
  parameter int WORD_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int N_WIDE   = 3,
  parameter int N_NARROW = 6,
  parameter int PW       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              narrow,
  input  logic [PW-1:0]     ptr,
  input  logic [WORD_W-1:0] data,
  output logic [CMD_W-1:0]  merged
);
  logic [CMD_W-1:0] raw_q;

  // Current contents with the piece on the bus placed in its slot.
  always_comb begin
    merged = raw_q;
    if (adv) begin
      if (narrow) begin
        for (int k = 0; k < N_NARROW; k++)
          if (ptr == PW'(k)) merged[CMD_W-1-BYTE_W*k -: BYTE_W] = data[BYTE_W-1:0];
      end else begin
        for (int k = 0; k < N_WIDE; k++)
          if (ptr == PW'(k)) merged[CMD_W-1-WORD_W*k -: WORD_W] = data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   raw_q <= '0;
    else if (clr) raw_q <= '0;
    else if (adv) raw_q <= merged;
  end

  // R10: software reset empties the staging register
  p_clr_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (raw_q == '0));
endmodule

// File: rtl/sdcp_finish.sv
module sdcp_finish
  import sdcp_pkg::*;
#(
  parameter int CMD_W = SDCP_CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fire,
  input  logic             crc_en,
  input  logic [CMD_W-1:0] merged,
  output logic [CMD_W-1:0] cmd_q,
  output logic             start_q
);
  logic [6:0]       crc_now;
  logic [CMD_W-1:0] final_cmd;

  assign crc_now = sdcp_crc7(merged[CMD_W-1:SDCP_CRC_LO]);

  always_comb begin
    final_cmd = merged;
    if (crc_en) final_cmd[7:1] = crc_now;
    final_cmd[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else if (clr) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= fire;
      if (fire) cmd_q <= final_cmd;
    end
  end

  // R5: strobe lasts one cycle
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R5: command holds between strobes
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !$past(clr)) |-> $stable(cmd_q));
  // R2: end bit set on every issued command
  p_endbit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> cmd_q[0]);
  // R3: checksum field matches the payload when auto mode was on
  p_crc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && $past(crc_en)) |-> (cmd_q[7:1] == sdcp_crc7(cmd_q[CMD_W-1:SDCP_CRC_LO])));
  // R10: software reset clears output state
  p_clr_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (cmd_q == '0 && !start_q));
endmodule

// File: rtl/sd_cmd_pipe.sv
module sd_cmd_pipe
  import sdcp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  byte_mode,
  input  logic                  crc_auto,
  output logic [SDCP_CMD_W-1:0] cmd_word,
  output logic                  cmd_start
);
  localparam int CMD_W    = SDCP_CMD_W;
  localparam int N_WIDE   = CMD_W / WORD_W;
  localparam int N_NARROW = CMD_W / BYTE_W;
  localparam int PW       = $clog2(N_NARROW);

  logic [PW-1:0]    slot;
  logic             seq_done;
  logic [CMD_W-1:0] staged;

  sdcp_ptr #(.N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .adv(wr_en),
    .narrow(byte_mode), .ptr(slot), .last_hit(seq_done)
  );

  sdcp_gather #(.CMD_W(CMD_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
                .N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .PW(PW)) u_gather (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .adv(wr_en),
    .narrow(byte_mode), .ptr(slot), .data(wr_data), .merged(staged)
  );

  sdcp_finish #(.CMD_W(CMD_W)) u_finish (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .fire(seq_done),
    .crc_en(crc_auto), .merged(staged), .cmd_q(cmd_word), .start_q(cmd_start)
  );

  // R5: a strobe only follows a sampled host write
  p_start_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(wr_en));
  // R10: no strobe right after a software reset
  p_no_start_after_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> !cmd_start);
endmodule

// File: tb/sd_cmd_pipe_bench.sv
`timescale 1ns/1ps
module sd_cmd_pipe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        byte_mode = 1'b0;
  logic        crc_auto = 1'b0;
  logic [47:0] cmd_word;
  logic        cmd_start;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sd_cmd_pipe u_sd_cmd_pipe (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .byte_mode(byte_mode), .crc_auto(crc_auto),
    .cmd_word(cmd_word), .cmd_start(cmd_start)
  );

  // {byte_mode, crc_auto, command as written}
  localparam logic [49:0] VECS [0:5] = '{
    {1'b0, 1'b1, 48'h4000_0000_00FF},
    {1'b0, 1'b0, 48'h5112_3456_78AA},
    {1'b1, 1'b1, 48'h4C00_0012_3433},
    {1'b1, 1'b0, 48'h7FFF_FFFF_FF00},
    {1'b0, 1'b1, 48'h77AB_CDEF_0102},
    {1'b1, 1'b1, 48'h4000_0000_0000}
  };

  // Remainder of polynomial division by 0x89 over payload followed by 7 zeros.
  function automatic logic [6:0] ref_crc(input logic [39:0] p);
    logic [46:0] v;
    v = {p, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  function automatic logic [47:0] expect_of(input logic [47:0] c, input logic ca);
    logic [47:0] e;
    e = c;
    if (ca) e[7:1] = ref_crc(c[47:8]);
    e[0] = 1'b1;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
  endtask

  task automatic send(input logic [47:0] c, input logic bm, input logic ca, input string req);
    int n;
    logic [47:0] e;
    n = bm ? 6 : 3;
    e = expect_of(c, ca);
    byte_mode = bm;
    crc_auto = ca;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) chk(cmd_start == 1'b0, {req, " R5 early strobe"}, 48'(cmd_start), 48'h0);
      wr_en = 1'b1;
      wr_data = bm ? {8'hC3, c[47 - 8*k -: 8]} : c[47 - 16*k -: 16];
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(cmd_start == 1'b1, {req, " R5 strobe"}, 48'(cmd_start), 48'h1);
    chk(cmd_word == e, {req, " word"}, cmd_word, e);
    @(negedge clk);
    chk(cmd_start == 1'b0, {req, " R5 one cycle"}, 48'(cmd_start), 48'h0);
    chk(cmd_word == e, {req, " R5 hold"}, cmd_word, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    chk(cmd_word == '0 && cmd_start == 1'b0, "R9 reset state", cmd_word, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R6 R7 R8 (back-to-back)
    for (int v = 0; v < 6; v++)
      send(VECS[v][47:0], VECS[v][49], VECS[v][48], $sformatf("R1/R6 vec%0d", v));

    // R3: CMD0 with zero argument ends in 0x95 (byte mode, junk 6th byte: R7)
    send(48'h4000_0000_00E7, 1'b1, 1'b1, "R3 R7 cmd0");
    chk(cmd_word[7:0] == 8'h95, "R3 cmd0 last byte", 48'(cmd_word[7:0]), 48'h95);

    // R4: written checksum bits kept, end bit forced (R2)
    send(48'h1234_5678_9A00, 1'b0, 1'b0, "R4 raw crc");
    chk(cmd_word[7:0] == 8'h01, "R4 R2 low byte", 48'(cmd_word[7:0]), 48'h01);

    // R11: idle cycles leave output alone
    repeat (5) @(negedge clk);
    chk(cmd_word == 48'h1234_5678_9A01 && !cmd_start, "R11 idle hold", cmd_word, 48'h1234_5678_9A01);

    // R10: soft reset mid-sequence, colliding with a write
    byte_mode = 1'b0;
    put(16'hDEAD);
    put(16'hBEEF);
    @(negedge clk);
    soft_rst = 1'b1;
    wr_en = 1'b1;
    wr_data = 16'hFFFF;
    @(negedge clk);
    soft_rst = 1'b0;
    wr_en = 1'b0;
    chk(cmd_word == '0 && !cmd_start, "R10 soft clear", cmd_word, 48'h0);
    send(48'h4A11_2233_4455, 1'b0, 1'b1, "R10 after soft");

    // R9: hardware reset mid-sequence
    byte_mode = 1'b1;
    put(16'h0011);
    put(16'h0022);
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_word == '0 && !cmd_start, "R9 mid reset", cmd_word, 48'h0);
    rst_n = 1'b1;
    send(48'h6655_4433_2211, 1'b1, 1'b0, "R9 after reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule